// File: doc/BRIEF.md
# HDR Field Exposure Timing Sequencer

This block is the global timing controller for an array of time-gated counting pixels. A frame is made of up to fifteen fields. Each field holds three exposures, short, mid and long, that follow each other with no gap. The exposures are bounded by rising edges on four gating lines. Gate 0 rises to open the short exposure. Gate 1 rises to close short and open mid. Gate 2 rises to close mid and open long. Gate 3 rises to close long. After the fourth edge the sequencer drops all gates, pulses a front-end reset to clear the pixel latches, and then pulses a count strobe so that each pixel adds its latched bits to its counters.

Software programs the three exposure lengths in reference clock cycles, the number of fields per frame, and a linear mode. In linear mode only gate 0 is used and each frame is a single field. A one-cycle start request launches a frame. The block samples its configuration at that moment. When the last count strobe has been issued it gives a one-cycle frame-ready pulse, which lets the readout take the counters.

Top module: `hdr_field_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, gate is 0000, fe_reset, cnt_inc and frame_ready are 0, and busy is 0.
- R2: Suppose start is high at a clock edge while the block is idle. From the next cycle, busy is 1 and gate equals 4'b0001 for exactly len_short cycles. Bit 0 of gate is the first gating line.
- R3: In HDR mode (lin_mode=0), gate equals 4'b0011 for len_mid cycles after the short exposure. It then equals 4'b0111 for len_long cycles, and then 4'b1111 for exactly one cycle.
- R4: An exposure length of 0 is handled as a length of 1 cycle.
- R5: After an HDR field closes, or after the single exposure in linear mode, the following happens. There is one cycle with fe_reset=1 and gate=0000. Then there is one cycle with cnt_inc=1 and gate=0000. If more fields remain, the next field's gate=4'b0001 phase starts in the cycle right after that.
- R6: A frame holds field_count fields, a value from 1 to 15; 0 is handled as 1. frame_ready is high for exactly one cycle, in the cycle after the last cnt_inc. After that the block is idle (busy=0, gate=0000).
- R7: In linear mode (lin_mode=1), gate[3:1] stay 0, gate[0] is high for len_short cycles, and each frame holds exactly one field whatever field_count is.
- R8: While busy, start has no effect, and changes on lin_mode, the length inputs and field_count do not change the running frame. These values are sampled only when start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a frame; accepted only when idle |
| lin_mode | input | 1 | 1 selects linear single-exposure mode |
| len_short | input | 16 | Short exposure length in cycles |
| len_mid | input | 16 | Mid exposure length in cycles |
| len_long | input | 16 | Long exposure length in cycles |
| field_count | input | 4 | Fields per frame (0 is handled as 1) |
| gate | output | 4 | Gating lines; rising edges bound the exposures |
| fe_reset | output | 1 | Front-end latch reset strobe |
| cnt_inc | output | 1 | Pixel counter increment strobe |
| frame_ready | output | 1 | One-cycle pulse when the frame is complete |
| busy | output | 1 | High while a frame is in progress |

## Verification
The hardest situation to reach from the ports is a configuration change that happens in the middle of a frame. The running frame must keep the lengths and field count it latched at start, while the inputs now show other values. The stimulus handles this by scrambling every configuration input a few cycles into selected frames and also pulsing start again. It then compares every cycle of gate and the strobes against a timeline model built from the values that were applied at start. Zero lengths, a field count of zero, field counts of 1 and 15, and a long exposure are covered by directed frames.

// File: rtl/hfs_pkg.sv
package hfs_pkg;
    localparam int LEN_W   = 16;
    localparam int FCNT_W  = 4;
    localparam int NGATE   = 4;
    localparam int LEVEL_W = $clog2(NGATE + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXP0,
        ST_EXP1,
        ST_EXP2,
        ST_CLOSE,
        ST_RST,
        ST_INC,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/hfs_len_timer.sv
module hfs_len_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = (load_val == '0) ? W'(1) : load_val;
        end else if (cnt_q > W'(1)) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= W'(1);
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == W'(1));

    AST_TIMER_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != '0); // R4
endmodule

// File: rtl/hfs_gate_decode.sv
module hfs_gate_decode #(
    parameter int NG  = 4,
    parameter int LVW = 3
) (
    input  logic [LVW-1:0] level,
    output logic [NG-1:0]  gate
);
    for (genvar i = 0; i < NG; i++) begin : g_line
        assign gate[i] = (level > LVW'(i));
    end
endmodule

// File: rtl/hdr_field_seq.sv
module hdr_field_seq
    import hfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              lin_mode,
    input  logic [LEN_W-1:0]  len_short,
    input  logic [LEN_W-1:0]  len_mid,
    input  logic [LEN_W-1:0]  len_long,
    input  logic [FCNT_W-1:0] field_count,
    output logic [NGATE-1:0]  gate,
    output logic              fe_reset,
    output logic              cnt_inc,
    output logic              frame_ready,
    output logic              busy
);
    typedef struct packed {
        seq_state_e        st;
        logic              lin;
        logic [LEN_W-1:0]  ls;
        logic [LEN_W-1:0]  lm;
        logic [LEN_W-1:0]  ll;
        logic [FCNT_W-1:0] nf;
        logic [FCNT_W-1:0] fidx;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic              tmr_load;
    logic [LEN_W-1:0]  tmr_val;
    logic              tmr_last;
    logic [LEVEL_W-1:0] level;

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = r_q.ls;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.lin  = lin_mode;
                    r_d.ls   = len_short;
                    r_d.lm   = len_mid;
                    r_d.ll   = len_long;
                    r_d.nf   = (lin_mode || field_count == '0) ? FCNT_W'(1) : field_count;
                    r_d.fidx = FCNT_W'(1);
                    r_d.st   = ST_EXP0;
                    tmr_load = 1'b1;
                    tmr_val  = len_short;
                end
            end
            ST_EXP0: begin
                if (tmr_last) begin
                    if (r_q.lin) begin
                        r_d.st = ST_RST;
                    end else begin
                        r_d.st   = ST_EXP1;
                        tmr_load = 1'b1;
                        tmr_val  = r_q.lm;
                    end
                end
            end
            ST_EXP1: begin
                if (tmr_last) begin
                    r_d.st   = ST_EXP2;
                    tmr_load = 1'b1;
                    tmr_val  = r_q.ll;
                end
            end
            ST_EXP2:  if (tmr_last) r_d.st = ST_CLOSE;
            ST_CLOSE: r_d.st = ST_RST;
            ST_RST:   r_d.st = ST_INC;
            ST_INC: begin
                if (r_q.fidx >= r_q.nf) begin
                    r_d.st = ST_DONE;
                end else begin
                    r_d.fidx = r_q.fidx + FCNT_W'(1);
                    r_d.st   = ST_EXP0;
                    tmr_load = 1'b1;
                    tmr_val  = r_q.ls;
                end
            end
            ST_DONE:  r_d.st = ST_IDLE;
            default:  r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, lin: 1'b0, ls: '0, lm: '0, ll: '0,
                     nf: FCNT_W'(1), fidx: FCNT_W'(1)};
        end else begin
            r_q <= r_d;
        end
    end

    hfs_len_timer #(.W(LEN_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    always_comb begin
        unique case (r_q.st)
            ST_EXP0:  level = LEVEL_W'(1);
            ST_EXP1:  level = LEVEL_W'(2);
            ST_EXP2:  level = LEVEL_W'(3);
            ST_CLOSE: level = LEVEL_W'(4);
            default:  level = '0;
        endcase
    end

    hfs_gate_decode #(.NG(NGATE), .LVW(LEVEL_W)) u_gdec (
        .level (level),
        .gate  (gate)
    );

    assign fe_reset    = (r_q.st == ST_RST);
    assign cnt_inc     = (r_q.st == ST_INC);
    assign frame_ready = (r_q.st == ST_DONE);
    assign busy        = (r_q.st != ST_IDLE);

    AST_GATE_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
        gate inside {4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111}); // R3
    AST_CLOSE_THEN_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (gate == 4'b1111) |=> (fe_reset && gate == 4'b0000)); // R5
    AST_RST_THEN_INC: assert property (@(posedge clk) disable iff (!rst_n)
        fe_reset |=> (cnt_inc && gate == 4'b0000)); // R5
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fe_reset, cnt_inc, frame_ready})); // R5
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ready |=> (!frame_ready && !busy)); // R6
    AST_READY_AFTER_INC: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ready |-> $past(cnt_inc)); // R6
    AST_LIN_ONE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && r_q.lin) |-> (gate[NGATE-1:1] == '0)); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !frame_ready) |=> busy); // R8
endmodule

// File: tb/hdr_field_seq_tb.sv
module hdr_field_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        lin_mode = 1'b0;
    logic [15:0] len_short = '0, len_mid = '0, len_long = '0;
    logic [3:0]  field_count = '0;
    logic [3:0]  gate;
    logic        fe_reset, cnt_inc, frame_ready, busy;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdr_field_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .lin_mode(lin_mode),
        .len_short(len_short), .len_mid(len_mid), .len_long(len_long),
        .field_count(field_count), .gate(gate), .fe_reset(fe_reset),
        .cnt_inc(cnt_inc), .frame_ready(frame_ready), .busy(busy)
    );

    task automatic chk(string tag, int act, int expv, int t);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s t=%0d actual=%0h expected=%0h", tag, t, act, expv);
        end
    endtask

    function automatic int eff(int v);
        return (v == 0) ? 1 : v;
    endfunction

    // expected outputs {busy, frame_ready, cnt_inc, fe_reset, gate[3:0]} at cycle t after start
    function automatic logic [7:0] expect_at(int t, int ls, int lm, int ll, int nf, bit lin);
        int s = eff(ls), m = eff(lm), l = eff(ll);
        int n = (lin || nf == 0) ? 1 : nf;
        int flen = lin ? s + 2 : s + m + l + 3;
        int total = n * flen + 1;
        int p;
        if (t >= total) return 8'h00;
        if (t == total - 1) return 8'hC0;
        p = t % flen;
        if (p < s) return 8'h81;
        if (!lin) begin
            if (p < s + m) return 8'h83;
            if (p < s + m + l) return 8'h87;
            if (p == s + m + l) return 8'h8F;
            p = p - (m + l + 1);
        end
        if (p == s) return 8'h90;
        return 8'hA0;
    endfunction

    task automatic run_frame(int ls, int lm, int ll, int nf, bit lin, bit disturb);
        int s = eff(ls), m = eff(lm), l = eff(ll);
        int n = (lin || nf == 0) ? 1 : nf;
        int total = n * (lin ? s + 2 : s + m + l + 3) + 1;
        logic [7:0] e;
        @(negedge clk);
        start = 1'b1; lin_mode = lin;
        len_short = 16'(ls); len_mid = 16'(lm); len_long = 16'(ll);
        field_count = 4'(nf);
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < total + 2; t++) begin
            e = expect_at(t, ls, lm, ll, nf, lin);
            chk(t == 0 ? "R2 gate" : (lin ? "R7 gate" : "R3 gate"), gate, e[3:0], t);
            chk("R5 fe_reset", fe_reset, e[4], t);
            chk("R5 cnt_inc", cnt_inc, e[5], t);
            chk("R6 frame_ready", frame_ready, e[6], t);
            chk(disturb ? "R8 busy" : "R6 busy", busy, e[7], t);
            if (disturb && t == 2) begin
                start = 1'b1; lin_mode = ~lin;
                len_short = 16'($urandom_range(1, 5)); len_mid = 16'd1;
                len_long = 16'd2; field_count = 4'(nf + 3);
            end else if (disturb && t == 3) begin
                start = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        #(CLK_PERIOD * 3 + 1);
        chk("R1 gate", gate, 0, -1);
        chk("R1 strobes", {fe_reset, cnt_inc, frame_ready, busy}, 0, -1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle gate", gate, 0, 0);
        chk("R1 idle busy", busy, 0, 0);
        // directed corners
        run_frame(1, 10, 100, 1, 1'b0, 1'b0);   // R3 ratio 10
        run_frame(0, 0, 0, 2, 1'b0, 1'b0);      // R4 zero lengths
        run_frame(2, 4, 8, 0, 1'b0, 1'b0);      // R6 field count 0 -> 1
        run_frame(1, 2, 3, 15, 1'b0, 1'b0);     // R6 full frame
        run_frame(5, 9, 9, 7, 1'b1, 1'b0);      // R7 linear
        run_frame(0, 3, 3, 4, 1'b1, 1'b0);      // R7 + R4
        run_frame(3, 6, 1000, 2, 1'b0, 1'b1);   // R8 long + disturb
        run_frame(4, 2, 2, 3, 1'b1, 1'b1);      // R8 linear disturb
        // random frames
        for (int i = 0; i < 30; i++) begin
            run_frame($urandom_range(0, 12), $urandom_range(0, 24),
                      $urandom_range(0, 40), $urandom_range(0, 15),
                      ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0));
        end
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule